// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit buffer descriptors in memory and turns each ready descriptor into a byte stream for a downstream MAC. Software builds descriptors and then pulses `kick`. The engine fetches the descriptor at its current ring position. If software owns that descriptor, the engine stops and waits for the next `kick`. If hardware owns it, the engine reads the length and buffer pointer, streams the buffer out over a valid/ready byte interface, and writes the control word back to hand the descriptor to software again. It then moves on to the next descriptor by itself.

A descriptor is four 16-bit words at byte offsets 0 (control), 2 (length), 4 (pointer bits 31:16) and 6 (pointer bits 15:0). The control word bits are: 15 owned-by-hardware, 13 wrap-to-base, 11 end-of-frame, 10 append CRC, 9 append inverted CRC. Bits 14 and 12 belong to software. The ring base must be a multiple of 8. Memory access uses a request/acknowledge port. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until the cycle in which `mem_ack` is high, and read data is taken in that same cycle.

The byte stream follows the usual valid/ready rules. A byte transfers on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, the data, last flag and tail code stay frozen. The sink may hold `tx_ready` low for as long as it needs to, and the engine does not fetch the next word until the current one has drained.

Top module: `txdesc_ring_engine`

## Requirements
- R1: After reset, `mem_req`, `tx_valid` and `err_pulse` are low. The first `kick` polls the control word at `ring_base`. A polled descriptor whose bit 15 is 0 causes no transfer and no write, and the engine waits for another `kick` before it polls that descriptor again.
- R2: For a descriptor owned by hardware, the engine reads offsets 0, 2, 4 and 6 of the descriptor, in that order, before any buffer access.
- R3: Exactly `length` bytes are sent from consecutive buffer addresses, high byte of each 16-bit word first. Under back-pressure, data, last flag and tail code hold steady until the byte is accepted.
- R4: An odd length sends only the high byte of the final word. A length of 0 sends no bytes, and the descriptor is still released.
- R5: `tx_last` is high only on the final byte of a descriptor whose bit 11 is set. The tail code on `tx_crc_mode` is shown together with that byte: 2'b10 when bit 9 is set (whatever bit 10 is), 2'b01 when only bit 10 is set, and 2'b00 when neither is set. On every other byte the tail code is 2'b00.
- R6: Release writes the control word back to offset 0 with only bit 15 cleared, so the software bits 14 and 12 are preserved. The engine never writes offsets 2, 4 or 6.
- R7: After a release, the next descriptor is at the current address plus 8 when bit 13 is 0, or at `ring_base` when bit 13 is 1. The engine polls it without waiting for a `kick`.
- R8: A buffer pointer whose low two bits are not zero sends no bytes, releases the descriptor, and raises `err_pulse` for exactly one cycle.
- R9: A memory request keeps its address and direction stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Byte address of the first descriptor in the ring |
| kick | input | 1 | One-cycle strobe that asks the engine to poll the ring |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while `mem_ack` is high |
| mem_ack | input | 1 | Completes the pending access |
| tx_valid | output | 1 | A byte is presented |
| tx_ready | input | 1 | The sink accepts the presented byte |
| tx_data | output | 8 | Byte to send |
| tx_last | output | 1 | Final byte of the frame |
| tx_crc_mode | output | 2 | Frame tail code: 00 none, 01 CRC, 10 inverted CRC |
| err_pulse | output | 1 | One-cycle pulse when a misaligned buffer is rejected |

## Verification
The main stream is tried with several input patterns, and each one tells a different fault apart:
- Odd and even lengths catch byte-order and trailing-byte mistakes.
- Zero length and a misaligned pointer separate "release without sending" from normal transmission.
- A two-descriptor chain, with a non-final buffer followed by a final one, shows whether the end flag and tail code are tied to the right descriptor.
- A sink that stalls in an irregular pattern shows whether bytes are lost or duplicated under back-pressure.
- Tail codes 00, 01 and 10 are each produced, including 10 with bit 10 also set, which checks the priority between bits 9 and 10.
- Wrap and non-wrap descriptors, checked against the address of the next poll, separate the two ways of advancing through the ring.

// File: rtl/txr_pkg.sv
package txr_pkg;
  parameter int unsigned ADDR_W     = 32;
  parameter int unsigned WORD_W     = 16;
  parameter int unsigned BYTE_W     = 8;
  parameter int unsigned ALIGN_BITS = 2;

  localparam int unsigned WORD_BYTES  = WORD_W / BYTE_W;
  localparam int unsigned CNT_W       = $clog2(WORD_BYTES + 1);
  localparam int unsigned DESC_WORDS  = 4;
  localparam int unsigned DESC_STRIDE = DESC_WORDS * WORD_BYTES;

  // control word bit positions (decoded by software as well)
  localparam int unsigned CB_OWN   = 15;
  localparam int unsigned CB_WRAP  = 13;
  localparam int unsigned CB_END   = 11;
  localparam int unsigned CB_CRC   = 10;
  localparam int unsigned CB_BADCRC = 9;

  typedef enum logic [1:0] {
    TAIL_NONE   = 2'b00,
    TAIL_CRC    = 2'b01,
    TAIL_BADCRC = 2'b10
  } tail_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_LEN, ST_PHI, ST_PLO, ST_DATA, ST_DRAIN, ST_REL
  } seq_e;
endpackage

// File: rtl/txr_tail_decode.sv
module txr_tail_decode
  import txr_pkg::*;
(
  input  logic [WORD_W-1:0] ctrl,
  output tail_e             tail
);
  always_comb begin
    if (ctrl[CB_BADCRC])   tail = TAIL_BADCRC;
    else if (ctrl[CB_CRC]) tail = TAIL_CRC;
    else                   tail = TAIL_NONE;
  end
endmodule

// File: rtl/txr_byte_serializer.sv
module txr_byte_serializer
  import txr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic              ends_frame,
  input  tail_e             tail_in,
  output logic              empty,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_last,
  output tail_e             tx_tail
);
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  left;
  logic              endf;
  tail_e             tail_q;

  assign empty    = (left == '0);
  assign tx_valid = !empty;
  assign tx_data  = shreg[WORD_W-1 -: BYTE_W];
  assign tx_last  = endf && (left == CNT_W'(1));
  assign tx_tail  = tx_last ? tail_q : TAIL_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      left   <= '0;
      endf   <= 1'b0;
      tail_q <= TAIL_NONE;
    end else if (load) begin
      shreg  <= word;
      left   <= nbytes;
      endf   <= ends_frame;
      tail_q <= tail_in;
    end else if (tx_valid && tx_ready) begin
      shreg <= shreg << BYTE_W;
      left  <= left - CNT_W'(1);
    end
  end
endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic [ADDR_W-1:0] ring_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              ser_empty,
  output logic              ser_load,
  output logic [CNT_W-1:0]  ser_nbytes,
  output logic              ser_final,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              err_pulse
);
  seq_e              st;
  logic [ADDR_W-1:0] cur;
  logic [ADDR_W-1:0] ptr;
  logic [WORD_W-1:0] ptr_hi;
  logic [WORD_W-1:0] remain;
  logic              started;
  logic              bad;

  localparam logic [WORD_W-1:0] PER_WORD = WORD_W'(WORD_BYTES);

  always_comb begin
    mem_req = 1'b1;
    mem_we  = 1'b0;
    unique case (st)
      ST_CTRL: mem_addr = cur;
      ST_LEN:  mem_addr = cur + ADDR_W'(WORD_BYTES);
      ST_PHI:  mem_addr = cur + ADDR_W'(2 * WORD_BYTES);
      ST_PLO:  mem_addr = cur + ADDR_W'(3 * WORD_BYTES);
      ST_DATA: mem_addr = ptr;
      ST_REL: begin
        mem_addr = cur;
        mem_we   = 1'b1;
      end
      default: begin
        mem_addr = cur;
        mem_req  = 1'b0;
      end
    endcase
    mem_wdata = ctrl_q & ~(WORD_W'(1) << CB_OWN);
  end

  assign ser_load   = (st == ST_DATA) && mem_ack;
  assign ser_nbytes = (remain >= PER_WORD) ? CNT_W'(WORD_BYTES) : CNT_W'(remain);
  assign ser_final  = (remain <= PER_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur       <= '0;
      ptr       <= '0;
      ptr_hi    <= '0;
      remain    <= '0;
      ctrl_q    <= '0;
      started   <= 1'b0;
      bad       <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= 1'b0;
      unique case (st)
        ST_IDLE: if (kick) begin
          if (!started) cur <= ring_base;
          started <= 1'b1;
          st      <= ST_CTRL;
        end
        ST_CTRL: if (mem_ack) begin
          ctrl_q <= mem_rdata;
          bad    <= 1'b0;
          st     <= mem_rdata[CB_OWN] ? ST_LEN : ST_IDLE;
        end
        ST_LEN: if (mem_ack) begin
          remain <= mem_rdata;
          st     <= ST_PHI;
        end
        ST_PHI: if (mem_ack) begin
          ptr_hi <= mem_rdata;
          st     <= ST_PLO;
        end
        ST_PLO: if (mem_ack) begin
          ptr <= ADDR_W'({ptr_hi, mem_rdata});
          if (mem_rdata[ALIGN_BITS-1:0] != '0) begin
            bad <= 1'b1;
            st  <= ST_REL;
          end else begin
            st <= (remain == '0) ? ST_REL : ST_DATA;
          end
        end
        ST_DATA: if (mem_ack) begin
          remain <= ser_final ? '0 : remain - PER_WORD;
          ptr    <= ptr + ADDR_W'(WORD_BYTES);
          st     <= ST_DRAIN;
        end
        ST_DRAIN: if (ser_empty) st <= (remain == '0) ? ST_REL : ST_DATA;
        ST_REL: if (mem_ack) begin
          err_pulse <= bad;
          cur <= ctrl_q[CB_WRAP] ? ring_base : cur + ADDR_W'(DESC_STRIDE);
          st  <= ST_CTRL;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txdesc_ring_engine.sv
module txdesc_ring_engine
  import txr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              kick,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_last,
  output logic [1:0]        tx_crc_mode,
  output logic              err_pulse
);
  logic              ser_empty, ser_load, ser_final;
  logic [CNT_W-1:0]  ser_nbytes;
  logic [WORD_W-1:0] ctrl_q;
  tail_e             tail, out_tail;

  txr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .kick(kick), .ring_base(ring_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .ser_empty(ser_empty), .ser_load(ser_load), .ser_nbytes(ser_nbytes),
    .ser_final(ser_final), .ctrl_q(ctrl_q), .err_pulse(err_pulse)
  );

  txr_tail_decode u_tail (.ctrl(ctrl_q), .tail(tail));

  txr_byte_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .load(ser_load), .word(mem_rdata),
    .nbytes(ser_nbytes), .ends_frame(ser_final && ctrl_q[CB_END]),
    .tail_in(tail), .empty(ser_empty), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .tx_tail(out_tail)
  );

  assign tx_crc_mode = out_tail;
endmodule

// File: rtl/txr_checker.sv
module txr_checker
  import txr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_last,
  input logic [1:0]        tx_crc_mode,
  input logic              err_pulse
);
  p_hold_stream_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_crc_mode));

  p_tail_on_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_last |-> tx_crc_mode == 2'b00);

  p_tail_code_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_crc_mode != 2'b11);

  p_release_clears_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[CB_OWN] && mem_addr[2:0] == 3'b000);

  p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  p_req_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

bind txdesc_ring_engine txr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_last(tx_last), .tx_crc_mode(tx_crc_mode), .err_pulse(err_pulse)
);

// File: tb/sim_txdesc_ring_engine.sv
module sim_txdesc_ring_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_base = 32'h40;
  logic        kick = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, tx_last, err_pulse;
  logic [7:0]  tx_data;
  logic [1:0]  tx_crc_mode;
  logic        bp_en = 1'b0;

  always #5 clk = ~clk;

  txdesc_ring_engine u0 (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .kick(kick),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_crc_mode(tx_crc_mode), .err_pulse(err_pulse)
  );

  logic [15:0] pre [0:255];
  logic [15:0] mem [0:255];
  int          wr_n, rd_n, ob_n, err_n;
  logic [31:0] wr_a [0:15];
  logic [15:0] wr_d [0:15];
  logic [31:0] rd_a [0:31];
  logic [7:0]  ob_d [0:31];
  logic        ob_l [0:31];
  logic [1:0]  ob_c [0:31];
  logic [3:0]  bp_cnt;

  // memory model: one-cycle acknowledge, preloaded from pre[] during reset
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pre[i];
      mem_ack <= 1'b0;
      mem_rdata <= '0;
      wr_n <= 0;
      rd_n <= 0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[8:1]] <= mem_wdata;
        if (wr_n < 16) begin
          wr_a[wr_n] <= mem_addr;
          wr_d[wr_n] <= mem_wdata;
        end
        wr_n <= wr_n + 1;
      end else begin
        mem_rdata <= mem[mem_addr[8:1]];
        if (rd_n < 32) rd_a[rd_n] <= mem_addr;
        rd_n <= rd_n + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      bp_cnt   <= '0;
      tx_ready <= 1'b0;
    end else begin
      bp_cnt   <= bp_cnt + 4'd1;
      tx_ready <= bp_en ? (bp_cnt[1:0] != 2'd1 && bp_cnt != 4'd6) : 1'b1;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      ob_n  <= 0;
      err_n <= 0;
    end else begin
      if (err_pulse) err_n <= err_n + 1;
      if (tx_valid && tx_ready) begin
        if (ob_n < 32) begin
          ob_d[ob_n] <= tx_data;
          ob_l[ob_n] <= tx_last;
          ob_c[ob_n] <= tx_crc_mode;
        end
        ob_n <= ob_n + 1;
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  logic wd_hit = 1'b0;

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic ceq(input string what, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, what, act, exp);
  endtask

  task automatic begin_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bp_en = 1'b0;
    for (int i = 0; i < 256; i++) pre[i] = 16'h0;
  endtask

  task automatic put_desc(input int a, input logic [15:0] c, input logic [15:0] l, input logic [31:0] p);
    pre[a/2]     = c;
    pre[a/2 + 1] = l;
    pre[a/2 + 2] = p[31:16];
    pre[a/2 + 3] = p[15:0];
  endtask

  task automatic end_reset_and_kick();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic settle(input int writes);
    for (int i = 0; i < 3000 && wr_n < writes; i++) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset();
    begin_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ceq("R1 mem_req after reset", mem_req, 0);
    ceq("R1 tx_valid after reset", tx_valid, 0);
    ceq("R1 err_pulse after reset", err_pulse, 0);
  endtask

  task automatic t_not_owned();
    begin_reset();
    put_desc(32'h40, 16'h5000, 16'd4, 32'h80);
    end_reset_and_kick();
    settle(0);
    ceq("R1 one poll", rd_n, 1);
    ceq("R1 poll at ring_base", rd_a[0], 32'h40);
    ceq("R1 no write", wr_n, 0);
    ceq("R1 no bytes", ob_n, 0);
    @(negedge clk); kick = 1'b1; @(negedge clk); kick = 1'b0;
    settle(0);
    ceq("R1 re-poll on kick", rd_n, 2);
    ceq("R1 re-poll address", rd_a[1], 32'h40);
  endtask

  task automatic t_odd_frame();
    begin_reset();
    put_desc(32'h40, 16'hDC00, 16'd5, 32'h80);
    pre[32'h80/2] = 16'h1122;
    pre[32'h82/2] = 16'h3344;
    pre[32'h84/2] = 16'h5566;
    end_reset_and_kick();
    settle(1);
    ceq("R2 word0", rd_a[0], 32'h40);
    ceq("R2 word1", rd_a[1], 32'h42);
    ceq("R2 word2", rd_a[2], 32'h44);
    ceq("R2 word3", rd_a[3], 32'h46);
    ceq("R2 buffer after desc", rd_a[4], 32'h80);
    ceq("R4 odd byte count", ob_n, 5);
    ceq("R3 byte0", ob_d[0], 8'h11);
    ceq("R3 byte1", ob_d[1], 8'h22);
    ceq("R3 byte3", ob_d[3], 8'h44);
    ceq("R4 trailing high byte", ob_d[4], 8'h55);
    ceq("R5 no last mid", ob_l[3], 0);
    ceq("R5 last on final", ob_l[4], 1);
    ceq("R5 tail crc", ob_c[4], 2'b01);
    ceq("R6 one write", wr_n, 1);
    ceq("R6 write addr", wr_a[0], 32'h40);
    ceq("R6 soft bits kept", wr_d[0], 16'h5C00);
    ceq("R6 length untouched", mem[32'h42/2], 16'd5);
    ceq("R7 next poll +8", rd_a[rd_n-1], 32'h48);
  endtask

  task automatic t_chain_wrap_bp();
    begin_reset();
    bp_en = 1'b1;
    put_desc(32'h40, 16'h8000, 16'd2, 32'h80);
    put_desc(32'h48, 16'hAE00, 16'd4, 32'h90);
    pre[32'h80/2] = 16'hA1B2;
    pre[32'h90/2] = 16'hC3D4;
    pre[32'h92/2] = 16'hE5F6;
    end_reset_and_kick();
    settle(2);
    ceq("R3 chain bytes", ob_n, 6);
    ceq("R3 bp byte1", ob_d[1], 8'hB2);
    ceq("R3 bp byte2", ob_d[2], 8'hC3);
    ceq("R3 bp byte5", ob_d[5], 8'hF6);
    ceq("R5 no last without end bit", ob_l[1], 0);
    ceq("R5 no tail without end bit", ob_c[1], 0);
    ceq("R5 last at frame end", ob_l[5], 1);
    ceq("R5 bad crc wins", ob_c[5], 2'b10);
    ceq("R6 release first", wr_d[0], 16'h0000);
    ceq("R6 release second addr", wr_a[1], 32'h48);
    ceq("R6 release second", wr_d[1], 16'h2E00);
    ceq("R7 wrap to base", rd_a[rd_n-1], 32'h40);
  endtask

  task automatic t_plain_end();
    begin_reset();
    put_desc(32'h40, 16'h8800, 16'd1, 32'hA0);
    pre[32'hA0/2] = 16'h7700;
    end_reset_and_kick();
    settle(1);
    ceq("R4 single byte", ob_n, 1);
    ceq("R4 single byte value", ob_d[0], 8'h77);
    ceq("R5 last plain", ob_l[0], 1);
    ceq("R5 tail none", ob_c[0], 2'b00);
  endtask

  task automatic t_zero_len();
    begin_reset();
    put_desc(32'h40, 16'hA000, 16'd0, 32'h80);
    end_reset_and_kick();
    settle(1);
    ceq("R4 zero length no bytes", ob_n, 0);
    ceq("R4 zero length release", wr_d[0], 16'h2000);
    ceq("R7 wrap re-poll count", rd_n, 5);
    ceq("R7 wrap re-poll addr", rd_a[4], 32'h40);
  endtask

  task automatic t_misaligned();
    begin_reset();
    put_desc(32'h40, 16'h8C00, 16'd4, 32'h82);
    end_reset_and_kick();
    settle(1);
    ceq("R8 no bytes", ob_n, 0);
    ceq("R8 one err cycle", err_n, 1);
    ceq("R8 release", wr_d[0], 16'h0C00);
    ceq("R8 no buffer read", rd_a[4], 32'h48);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_not_owned();
        t_odd_frame();
        t_chain_wrap_bp();
        t_plain_end();
        t_zero_len();
        t_misaligned();
      end
      begin
        repeat (100000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) chk(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule